// File: doc/BRIEF.md
# Dual-Rail Early Completion Detector

This block produces the handshake for one stage of a dual-rail, delay-insensitive pipeline. It looks at the dual-rail word arriving at the preceding register (its inputs, not its outputs) and at the acknowledge coming back from the next stage. It then drives the request sent to the previous stage. Two rails carry each bit: rail0 high means logic 0, rail1 high means logic 1, both low means the bit is empty (NULL), and both high is an illegal code.

Bits are taken two at a time. Each pair feeds a completion gate with hysteresis. The gate sets when both bits hold a value and clears when all four rails are low. A merge gate collects all the pair gates. A final two-input hysteresis gate combines the merge result with the downstream acknowledge. That final gate is the stage's handshake state. Its inverse is the request sent upstream, and its direct value is the sleep control for the stage's combinational logic. Sleep is therefore asserted only when the stage's inputs are complete and the stage itself has asked for NULL, so no separate sleep generator is needed.

Each threshold gate is modelled as a register updated by a simulation clock. As a result, a complete wavefront reaches the outputs after a fixed number of cycles.

Top module: `wave_completion_detector`

## Requirements
- R1: While reset is high and in the first cycle after it is released, ko is 1 (request-for-DATA), sleep is 0 and railFault is 0.
- R2: Bit i of the word uses dataRails[2i] as rail0 and dataRails[2i+1] as rail1. Bits 2g and 2g+1 form completion group g. A word whose rail0 lines are all high counts as complete DATA.
- R3: With ki at 1, ko falls to 0 three clock edges after the edge at which the last bit of the word becomes DATA. It is still 1 after two edges.
- R4: With ki at 0, ko rises to 1 three clock edges after the edge at which the last rail of the word becomes low. It is still 0 after two edges.
- R5: A partial wavefront never changes ko. This covers any word in which some bits hold a value and others are NULL, including a word with every group half filled.
- R6: While ki disagrees with the state of the word, ko holds. When ki comes to agree with a complete word (or with a fully NULL word), ko changes one edge later, and always to the inverse of the ki value that caused the change.
- R7: sleep is always the inverse of ko.
- R8: railFault is 1 one edge after any bit presents both rails high, and 0 one edge after no bit does.
- R9: The logic values carried by a complete word (all zeros, all ones or mixed) do not affect the timing or result of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock that advances the gate models |
| rst | input | 1 | Synchronous active-high reset; forces every gate low |
| dataRails | input | 2*WIDTH | Dual-rail word at the preceding register input, two rails per bit |
| ki | input | 1 | Acknowledge from the next stage: 1 asks for DATA, 0 asks for NULL |
| ko | output | 1 | Request to the previous stage: 1 asks for DATA, 0 asks for NULL |
| sleep | output | 1 | Puts the stage's combinational logic to sleep while high |
| railFault | output | 1 | High when the previous cycle's word held an illegal (1,1) pair |

## Verification
Suppose a pair gate or the merge gate loses its hysteresis or clears at the wrong time. A partial wavefront would then move ko, and that shows at ko within three edges of the partial word. The same fault can also cause a missed or early transition at the three-edge point of a complete word. If the final gate mis-holds, ko changes against ki, visible one edge after ki moves. A wrong pair grouping shows up only with half-filled groups, so the stimulus includes words where every group has exactly one bit present.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  // Strobes handed from the gate network to the handshake control.
  typedef struct packed {
    logic treeDone;   // merge gate: every pair gate is set
    logic railClash;  // registered illegal-code flag
  } wcdStrobes_t;

  // Set condition of a two-bit completion gate: (A+B)&(C+D) over
  // rails {bit1.rail1, bit1.rail0, bit0.rail1, bit0.rail0}.
  function automatic logic pairSet(input logic [3:0] quad);
    return (quad[0] | quad[1]) & (quad[2] | quad[3]);
  endfunction

endpackage

// File: rtl/wcd_datapath.sv
module wcd_datapath
  import wcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*WIDTH-1:0] dataRails,
  output wcdStrobes_t        strobes
);

  localparam int GROUPS     = WIDTH / 2;
  localparam int GROUP_RAIL = 4;

  logic [GROUPS-1:0] compQ;
  logic              treeQ;
  logic [WIDTH-1:0]  clashBits;
  logic              clashQ;

  // One hysteresis completion gate per pair of bits.
  generate
    for (genvar g = 0; g < GROUPS; g++) begin : gPair
      logic [GROUP_RAIL-1:0] quad;
      assign quad = dataRails[g*GROUP_RAIL +: GROUP_RAIL];
      always_ff @(posedge clk) begin
        if (rst)                  compQ[g] <= 1'b0;
        else if (pairSet(quad))   compQ[g] <= 1'b1;
        else if (quad == '0)      compQ[g] <= 1'b0;
      end
    end
  endgenerate

  // Merge gate: sets when all pair gates are set, clears when none are.
  always_ff @(posedge clk) begin
    if (rst)                treeQ <= 1'b0;
    else if (&compQ)        treeQ <= 1'b1;
    else if (compQ == '0)   treeQ <= 1'b0;
  end

  // Illegal (1,1) code on any bit.
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : gClash
      assign clashBits[b] = dataRails[2*b] & dataRails[2*b+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clashQ <= 1'b0;
    else     clashQ <= |clashBits;
  end

  assign strobes.treeDone  = treeQ;
  assign strobes.railClash = clashQ;

endmodule

// File: rtl/wcd_control.sv
module wcd_control
  import wcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  wcdStrobes_t strobes,
  input  logic        ki,
  output logic        ko,
  output logic        sleep,
  output logic        railFault
);

  logic handQ;

  // Two-input hysteresis gate joining the word state with ki.
  always_ff @(posedge clk) begin
    if (rst)                             handQ <= 1'b0;
    else if (strobes.treeDone && ki)     handQ <= 1'b1;
    else if (!strobes.treeDone && !ki)   handQ <= 1'b0;
  end

  assign ko        = ~handQ;
  assign sleep     = handQ;
  assign railFault = strobes.railClash;

endmodule

// File: rtl/wave_completion_detector.sv
module wave_completion_detector
  import wcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*WIDTH-1:0] dataRails,
  input  logic               ki,
  output logic               ko,
  output logic               sleep,
  output logic               railFault
);

  wcdStrobes_t strobes;

  wcd_datapath #(.WIDTH(WIDTH)) uDatapath (
    .clk       (clk),
    .rst       (rst),
    .dataRails (dataRails),
    .strobes   (strobes)
  );

  wcd_control uControl (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .ki        (ki),
    .ko        (ko),
    .sleep     (sleep),
    .railFault (railFault)
  );

endmodule

// File: rtl/wcd_checker.sv
module wcd_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [2*WIDTH-1:0] dataRails,
  input logic               ki,
  input logic               ko,
  input logic               railFault
);

  logic allData;
  logic allNull;
  logic anyClash;

  always_comb begin
    allData  = 1'b1;
    anyClash = 1'b0;
    for (int b = 0; b < WIDTH; b++) begin
      allData  = allData & (dataRails[2*b] ^ dataRails[2*b+1]);
      anyClash = anyClash | (dataRails[2*b] & dataRails[2*b+1]);
    end
    allNull = (dataRails == '0);
  end

  // R3: complete DATA word two edges ago plus ki high gives request-for-NULL
  a_r3_data_then_null_request: assert property (@(posedge clk) disable iff (rst)
    ($past(allData, 2) && !$past(rst, 2) && !$past(rst) && ki) |=> !ko);

  // R4: empty word two edges ago plus ki low gives request-for-DATA
  a_r4_null_then_data_request: assert property (@(posedge clk) disable iff (rst)
    ($past(allNull, 2) && !$past(rst, 2) && !$past(rst) && !ki) |=> ko);

  // R6: a change of ko always follows the value ki held one edge earlier
  a_r6_ko_follows_ki: assert property (@(posedge clk) disable iff (rst)
    !$stable(ko) |-> (ko != $past(ki)));

  // R8: illegal code is flagged on the next edge
  a_r8_fault_raise: assert property (@(posedge clk) disable iff (rst)
    anyClash |=> railFault);

  // R8: flag clears on the next edge after a clean word
  a_r8_fault_clear: assert property (@(posedge clk) disable iff (rst)
    !anyClash |=> !railFault);

endmodule

bind wave_completion_detector wcd_checker #(.WIDTH(WIDTH)) uChecker (
  .clk       (clk),
  .rst       (rst),
  .dataRails (dataRails),
  .ki        (ki),
  .ko        (ko),
  .railFault (railFault)
);

// File: tb/wave_completion_detector_test.sv
module wave_completion_detector_test;

  localparam int WIDTH = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2*WIDTH-1:0] dataRails = '0;
  logic               ki = 1'b0;
  logic               ko, sleep, railFault;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wave_completion_detector #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .dataRails(dataRails), .ki(ki),
    .ko(ko), .sleep(sleep), .railFault(railFault)
  );

  // Behavioural reference: word status -> merged state -> handshake state.
  logic mAll, mNone, mTree, mHand, mFault;

  function automatic logic wordData(input logic [2*WIDTH-1:0] r);
    for (int b = 0; b < WIDTH; b++)
      if (r[2*b] == r[2*b+1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic wordClash(input logic [2*WIDTH-1:0] r);
    for (int b = 0; b < WIDTH; b++)
      if (r[2*b] && r[2*b+1]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mAll <= 1'b0; mNone <= 1'b1; mTree <= 1'b0; mHand <= 1'b0; mFault <= 1'b0;
    end else begin
      mAll   <= wordData(dataRails);
      mNone  <= (dataRails == '0);
      mTree  <= mAll ? 1'b1 : (mNone ? 1'b0 : mTree);
      mHand  <= (mTree && ki) ? 1'b1 : ((!mTree && !ki) ? 1'b0 : mHand);
      mFault <= wordClash(dataRails);
    end
  end

  task automatic check(input string tag, input logic actual, input logic expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, actual, expected, $time);
    end
  endtask

  // Cycle comparison against the reference, away from the edge.
  always @(posedge clk) begin
    #1;
    if (running && !rst) begin
      check("R5 ko vs model", ko, ~mHand);
      check("R7 sleep vs model", sleep, mHand);
      check("R8 railFault vs model", railFault, mFault);
    end
  end

  function automatic logic [2*WIDTH-1:0] makeWord(input logic [WIDTH-1:0] val,
                                                  input logic [WIDTH-1:0] present);
    logic [2*WIDTH-1:0] w;
    w = '0;
    for (int b = 0; b < WIDTH; b++)
      if (present[b]) begin
        w[2*b]   = ~val[b];
        w[2*b+1] = val[b];
      end
    return w;
  endfunction

  task automatic drive(input logic [2*WIDTH-1:0] w);
    @(negedge clk);
    dataRails = w;
  endtask

  task automatic setKi(input logic v);
    @(negedge clk);
    ki = v;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full wavefront cycle with timing checks on both transitions.
  task automatic fullCycle(input logic [WIDTH-1:0] val, input string tag);
    setKi(1'b1);
    drive(makeWord(val, 8'h0F));
    waitNeg(4);
    check({tag, " R5 partial"}, ko, 1'b1);
    drive(makeWord(val, 8'hFF));
    waitNeg(2);
    check({tag, " R3 not yet"}, ko, 1'b1);
    waitNeg(1);
    check({tag, " R3 ko low"}, ko, 1'b0);
    check({tag, " R7 sleep high"}, sleep, 1'b1);
    setKi(1'b0);
    drive(makeWord(val, 8'hF0));
    waitNeg(4);
    check({tag, " R5 partial null"}, ko, 1'b0);
    drive('0);
    waitNeg(2);
    check({tag, " R4 not yet"}, ko, 1'b0);
    waitNeg(1);
    check({tag, " R4 ko high"}, ko, 1'b1);
  endtask

  initial begin
    waitNeg(3);
    check("R1 ko in reset", ko, 1'b1);
    check("R1 sleep in reset", sleep, 1'b0);
    rst = 1'b0;
    running = 1'b1;
    waitNeg(1);
    check("R1 ko after reset", ko, 1'b1);
    check("R1 sleep after reset", sleep, 1'b0);
    check("R1 railFault after reset", railFault, 1'b0);

    // R2 / R9: all DATA0 (rail0 lines), all DATA1, mixed
    fullCycle(8'h00, "R2 R9 zeros");
    fullCycle(8'hFF, "R9 ones");
    fullCycle(8'hA5, "R9 mixed");

    // R2 / R5: every group half filled must not complete
    setKi(1'b1);
    drive(makeWord(8'h3C, 8'h55));
    waitNeg(5);
    check("R2 R5 half groups", ko, 1'b1);
    drive('0);
    waitNeg(3);

    // R6: complete word while ki asks for NULL -> hold, then ki releases
    setKi(1'b0);
    drive(makeWord(8'h5A, 8'hFF));
    waitNeg(5);
    check("R6 hold while ki low", ko, 1'b1);
    setKi(1'b1);
    waitNeg(1);
    check("R6 ko falls one edge after ki", ko, 1'b0);
    // empty word while ki asks for DATA -> hold
    drive('0);
    waitNeg(5);
    check("R6 hold while ki high", ko, 1'b0);
    setKi(1'b0);
    waitNeg(1);
    check("R6 ko rises one edge after ki", ko, 1'b1);

    // R8: illegal code on bit 5
    drive(16'h0C00);
    waitNeg(1);
    check("R8 fault raised", railFault, 1'b1);
    check("R8 R5 ko unaffected", ko, 1'b1);
    drive('0);
    waitNeg(1);
    check("R8 fault cleared", railFault, 1'b0);
    waitNeg(3);

    running = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule